// File: doc/BRIEF.md
# Data Memory Operand Address Unit

This block resolves the data-memory operand of one instruction of a small 8-bit microcontroller core and carries out the access. The core presents an operation (load, store, exchange), an addressing mode, the instruction's operand byte and the current accumulator, and pulses `start`. The block forms the low address byte from the operand byte or from one of two pointer registers. It takes the upper address byte from its segment register. It then reads and/or writes the addressed location, optionally steps the pointer, and one clock later returns the old contents of the location together with the new accumulator value.

The block owns all state the operand path can reach. This is a sixteen-entry register window at low offsets F0h–FFh, which every segment reaches in the same way, and which holds twelve general registers, the two pointers, the stack pointer and the segment register. It also owns a RAM bank for segment 0 and one RAM bank for each of the upper segments. Because the pointers and the segment register sit inside the data space, an instruction can address them directly. An instruction that steps a pointer can also address that pointer through itself.

Top module: `opaddr_unit`

## Requirements
- R1: In direct mode (`mode`=0) the low address byte is `instr_byte` and the upper byte is the segment register.
- R2: In pointer modes the low address byte is the B register (`mode` 1, 3, 4) or the X register (`mode` 2, 5, 6), and the upper byte is the segment register.
- R3: Modes 3 and 5 add one to the pointer they used, and modes 4 and 6 subtract one from it, modulo 256. This happens after the access and for every operation except code 3.
- R4: In immediate mode (`mode`=7) `rd_data` is `instr_byte`. Load and exchange put `instr_byte` in the accumulator, store leaves the accumulator alone, and no register or RAM changes.
- R5: Exchange (`op`=2) writes `acc_in` to the location and returns the location's old contents as both `rd_data` and `acc_out`.
- R6: Load (`op`=0) returns the location as `acc_out`. Store (`op`=1) writes `acc_in` and returns `acc_out`=`acc_in`. Both return the old location value on `rd_data`.
- R7: Low offsets F0h–FBh are twelve general registers, FCh is X, FDh is SP, FEh is B and FFh is the segment register. These are the same storage whatever the segment.
- R8: In segment 0, offsets 00h–6Fh are RAM. Reads of 70h–7Fh return FFh, and writes there are ignored.
- R9: Segments 1 to 3 hold RAM at offsets 00h–7Fh. Offsets 80h–EFh in any segment, and every offset below F0h in segments above 3, read 00h and ignore writes.
- R10: When a stepping access writes the pointer it steps, the pointer ends as the written value plus or minus one.
- R11: `done` is high in exactly the cycle after each cycle with `start` high. After reset `done`, `rd_data`, `acc_out`, all registers and all RAM are zero.
- R12: Operation code 3 changes no register or RAM, and returns `acc_out`=`acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Perform one access this cycle |
| op | input | 2 | 0 load, 1 store, 2 exchange, 3 none |
| mode | input | 3 | 0 direct, 1 [B], 2 [X], 3 [B]+, 4 [B]-, 5 [X]+, 6 [X]-, 7 immediate |
| instr_byte | input | 8 | Operand byte of the instruction |
| acc_in | input | 8 | Current accumulator |
| done | output | 1 | Result valid |
| rd_data | output | 8 | Old contents of the operand |
| acc_out | output | 8 | Accumulator after the instruction |

## Verification
On every cycle, the assertions check the start/done timing, the accumulator pass-through on store, the stillness of pointers and segment in immediate mode, single-step pointer movement when no write hits that pointer, and the all-ones window of segment 0. Some properties span several accesses: segment switching, window sharing across segments, aliasing in empty segments, and a pointer stepping after it has been overwritten through itself. Only the bench's directed and random sequences can show these, because its reference model carries the whole memory from one access to the next.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_XCHG  = 2'd2,
      OP_NONE  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      AM_DIRECT = 3'd0,
      AM_IND_B  = 3'd1,
      AM_IND_X  = 3'd2,
      AM_B_INC  = 3'd3,
      AM_B_DEC  = 3'd4,
      AM_X_INC  = 3'd5,
      AM_X_DEC  = 3'd6,
      AM_IMM    = 3'd7
   } amode_e;

   // register window indices (low nibble of F0h..FFh)
   localparam logic [3:0] WIN_X  = 4'hC;
   localparam logic [3:0] WIN_SP = 4'hD;
   localparam logic [3:0] WIN_B  = 4'hE;
   localparam logic [3:0] WIN_S  = 4'hF;
   localparam logic [3:0] WIN_HI = 4'hF;   // upper nibble marking the window

   typedef struct packed {
      logic imm;      // no memory access
      logic use_ptr;  // low byte from a pointer
      logic ptr_x;    // X instead of B
      logic step;     // post-adjust pointer
      logic down;     // step direction
   } mdec_t;

   function automatic mdec_t decode_mode(amode_e m);
      mdec_t d;
      d = '0;
      case (m)
         AM_DIRECT: ;
         AM_IND_B:  d.use_ptr = 1'b1;
         AM_IND_X:  begin d.use_ptr = 1'b1; d.ptr_x = 1'b1; end
         AM_B_INC:  begin d.use_ptr = 1'b1; d.step = 1'b1; end
         AM_B_DEC:  begin d.use_ptr = 1'b1; d.step = 1'b1; d.down = 1'b1; end
         AM_X_INC:  begin d.use_ptr = 1'b1; d.ptr_x = 1'b1; d.step = 1'b1; end
         AM_X_DEC:  begin d.use_ptr = 1'b1; d.ptr_x = 1'b1; d.step = 1'b1; d.down = 1'b1; end
         AM_IMM:    d.imm = 1'b1;
         default:   ;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/opaddr_agen.sv
module opaddr_agen
   import opaddr_pkg::*;
#(
   parameter int DW = 8
) (
   input  amode_e        mode,
   input  logic [DW-1:0] instr_byte,
   input  logic [DW-1:0] ptr_b,
   input  logic [DW-1:0] ptr_x,
   output logic [DW-1:0] lo_addr,
   output logic          mem_access,
   output logic          in_window,
   output logic [3:0]    win_idx,
   output logic          step_en,
   output logic          step_down,
   output logic [3:0]    step_idx
);
   mdec_t dec;

   always_comb begin
      dec        = decode_mode(mode);
      if (!dec.use_ptr)  lo_addr = instr_byte;
      else if (dec.ptr_x) lo_addr = ptr_x;
      else                lo_addr = ptr_b;
      mem_access = !dec.imm;
      in_window  = (lo_addr[DW-1:DW-4] == WIN_HI);
      win_idx    = lo_addr[3:0];
      step_en    = dec.step;
      step_down  = dec.down;
      step_idx   = dec.ptr_x ? WIN_X : WIN_B;
   end

endmodule

// File: rtl/opaddr_regbank.sv
module opaddr_regbank
   import opaddr_pkg::*;
#(
   parameter int DW    = 8,
   parameter int NREGS = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    rd_idx,
   output logic [DW-1:0] rdata,
   input  logic          wr_en,
   input  logic [3:0]    wr_idx,
   input  logic [DW-1:0] wdata,
   input  logic          step_en,
   input  logic          step_down,
   input  logic [3:0]    step_idx,
   output logic [DW-1:0] ptr_b,
   output logic [DW-1:0] ptr_x,
   output logic [DW-1:0] seg
);
   if (NREGS != 16) begin : g_bad_nregs
      $error("opaddr_regbank: window must hold exactly 16 registers");
   end

   logic [DW-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam logic [3:0] MY_IDX = 4'(i);
      logic [DW-1:0] nxt;
      always_comb begin
         nxt = regs[i];
         if (wr_en && wr_idx == MY_IDX) nxt = wdata;
         // step after the write so a self-addressed pointer moves from the new value
         if (step_en && step_idx == MY_IDX)
            nxt = step_down ? nxt - DW'(1) : nxt + DW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) regs[i] <= '0;
         else        regs[i] <= nxt;
      end
   end

   assign rdata = regs[rd_idx];
   assign ptr_b = regs[WIN_B];
   assign ptr_x = regs[WIN_X];
   assign seg   = regs[WIN_S];

endmodule

// File: rtl/opaddr_segram.sv
module opaddr_segram #(
   parameter int DW        = 8,
   parameter int SEG0_BYTES = 112,
   parameter int SEG_BYTES  = 128,
   parameter int RAM_SEGS   = 3,
   parameter int ONES_LO    = 'h70,
   parameter int ONES_HI    = 'h7F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] seg,
   input  logic [DW-1:0] off,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int IDX0_W = (SEG0_BYTES > 1) ? $clog2(SEG0_BYTES) : 1;
   localparam int IDXN_W = (SEG_BYTES > 1) ? $clog2(SEG_BYTES) : 1;
   localparam logic [DW-1:0] SEG0_LIM = DW'(SEG0_BYTES);
   localparam logic [DW-1:0] SEGN_LIM = DW'(SEG_BYTES);
   localparam logic [DW-1:0] ONES_L   = DW'(ONES_LO);
   localparam logic [DW-1:0] ONES_H   = DW'(ONES_HI);

   if (SEG_BYTES > 240 || SEG0_BYTES > 240) begin : g_bad_size
      $error("opaddr_segram: RAM would overlap the register window");
   end
   if (SEG0_BYTES > ONES_LO || ONES_HI < ONES_LO) begin : g_bad_ones
      $error("opaddr_segram: all-ones window must sit above segment-0 RAM");
   end
   if (RAM_SEGS < 1 || RAM_SEGS > 254) begin : g_bad_segs
      $error("opaddr_segram: upper segment count out of range");
   end

   logic [DW-1:0] seg0_rd;
   logic          seg0_sel;
   logic          ones_hit;
   assign seg0_sel = (seg == '0);
   assign ones_hit = seg0_sel && off >= ONES_L && off <= ONES_H;

   if (SEG0_BYTES > 0) begin : g_seg0
      logic [DW-1:0] mem [SEG0_BYTES];
      logic          hit;
      assign hit = seg0_sel && off < SEG0_LIM;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SEG0_BYTES; i++) mem[i] <= '0;
         end else if (wr_en && hit) begin
            mem[off[IDX0_W-1:0]] <= wdata;
         end
      end
      assign seg0_rd = hit ? mem[off[IDX0_W-1:0]] : '0;
   end else begin : g_no_seg0
      assign seg0_rd = '0;
   end

   logic [DW-1:0] up_rd [RAM_SEGS];

   for (genvar g = 0; g < RAM_SEGS; g++) begin : g_seg
      localparam logic [DW-1:0] MY_SEG = DW'(g + 1);
      logic [DW-1:0] mem [SEG_BYTES];
      logic          hit;
      assign hit = (seg == MY_SEG) && off < SEGN_LIM;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SEG_BYTES; i++) mem[i] <= '0;
         end else if (wr_en && hit) begin
            mem[off[IDXN_W-1:0]] <= wdata;
         end
      end
      assign up_rd[g] = hit ? mem[off[IDXN_W-1:0]] : '0;
   end

   logic [DW-1:0] up_any;
   always_comb begin
      up_any = '0;
      for (int g = 0; g < RAM_SEGS; g++) up_any = up_any | up_rd[g];
   end

   always_comb begin
      if (ones_hit)      rdata = '1;
      else if (seg0_sel) rdata = seg0_rd;
      else               rdata = up_any;
   end

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
   import opaddr_pkg::*;
#(
   parameter int DW         = 8,
   parameter int SEG0_BYTES = 112,
   parameter int SEG_BYTES  = 128,
   parameter int RAM_SEGS   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic [2:0]    mode,
   input  logic [DW-1:0] instr_byte,
   input  logic [DW-1:0] acc_in,
   output logic          done,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] acc_out
);
   if (DW != 8) begin : g_bad_dw
      $error("opaddr_unit: the register window layout needs an 8-bit data path");
   end

   op_e           op_q;
   amode_e        mode_q;
   logic [DW-1:0] lo_addr, ptr_b, ptr_x, seg;
   logic [DW-1:0] reg_rd, ram_rd, rd_val, acc_nxt;
   logic          mem_access, in_window, step_en, step_down;
   logic [3:0]    win_idx, step_idx;
   logic          writes, wr_reg, wr_ram, do_step;

   assign op_q   = op_e'(op);
   assign mode_q = amode_e'(mode);

   opaddr_agen #(.DW(DW)) u_agen (
      .mode       (mode_q),
      .instr_byte (instr_byte),
      .ptr_b      (ptr_b),
      .ptr_x      (ptr_x),
      .lo_addr    (lo_addr),
      .mem_access (mem_access),
      .in_window  (in_window),
      .win_idx    (win_idx),
      .step_en    (step_en),
      .step_down  (step_down),
      .step_idx   (step_idx)
   );

   assign writes  = start && mem_access && (op_q == OP_STORE || op_q == OP_XCHG);
   assign wr_reg  = writes && in_window;
   assign wr_ram  = writes && !in_window;
   assign do_step = start && step_en && (op_q != OP_NONE);

   opaddr_regbank #(.DW(DW), .NREGS(16)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (win_idx),
      .rdata     (reg_rd),
      .wr_en     (wr_reg),
      .wr_idx    (win_idx),
      .wdata     (acc_in),
      .step_en   (do_step),
      .step_down (step_down),
      .step_idx  (step_idx),
      .ptr_b     (ptr_b),
      .ptr_x     (ptr_x),
      .seg       (seg)
   );

   opaddr_segram #(
      .DW         (DW),
      .SEG0_BYTES (SEG0_BYTES),
      .SEG_BYTES  (SEG_BYTES),
      .RAM_SEGS   (RAM_SEGS),
      .ONES_LO    ('h70),
      .ONES_HI    ('h7F)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .seg   (seg),
      .off   (lo_addr),
      .wr_en (wr_ram),
      .wdata (acc_in),
      .rdata (ram_rd)
   );

   always_comb begin
      if (!mem_access)    rd_val = instr_byte;
      else if (in_window) rd_val = reg_rd;
      else                rd_val = ram_rd;
      case (op_q)
         OP_LOAD, OP_XCHG: acc_nxt = rd_val;
         default:          acc_nxt = acc_in;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         rd_data <= '0;
         acc_out <= '0;
      end else begin
         done <= start;
         if (start) begin
            rd_data <= rd_val;
            acc_out <= acc_nxt;
         end
      end
   end

   // R11
   done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   // R6
   store_acc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 2'd1) |=> acc_out == $past(acc_in));
   // R4
   imm_state_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == 3'd7) |=>
         (ptr_b == $past(ptr_b) && ptr_x == $past(ptr_x) && seg == $past(seg)));
   // R3
   b_inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == 3'd3 && op != 2'd3 && !(wr_reg && win_idx == WIN_B))
         |=> ptr_b == $past(ptr_b) + 8'd1);
   // R3
   x_dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode == 3'd6 && op != 2'd3 && !(wr_reg && win_idx == WIN_X))
         |=> ptr_x == $past(ptr_x) - 8'd1);
   // R8
   seg0_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode != 3'd7 && seg == '0 && lo_addr[7:4] == 4'h7)
         |=> rd_data == 8'hFF);

endmodule

// File: tb/opaddr_unit_bench.sv
module opaddr_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op = '0;
   logic [2:0] mode = '0;
   logic [7:0] instr_byte = '0;
   logic [7:0] acc_in = '0;
   logic       done;
   logic [7:0] rd_data, acc_out;

   always #10 clk = ~clk;   // 50 MHz

   opaddr_unit u_opaddr_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode),
      .instr_byte(instr_byte), .acc_in(acc_in),
      .done(done), .rd_data(rd_data), .acc_out(acc_out)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [7:0] m_reg [16];
   logic [7:0] m_ram [4][128];
   logic [7:0] cur_acc = '0;

   // expectation for the next post-edge sample
   logic       exp_done = 1'b0;
   logic [7:0] exp_rd = '0;
   logic [7:0] exp_acc = '0;
   string      exp_tag = "R11";
   bit         mon_on = 1'b0;

   function automatic logic [7:0] m_read(logic [7:0] lo);
      logic [7:0] s;
      s = m_reg[15];
      if (lo >= 8'hF0) return m_reg[lo[3:0]];
      if (s == 8'd0) begin
         if (lo < 8'h70) return m_ram[0][lo[6:0]];
         if (lo < 8'h80) return 8'hFF;
         return 8'h00;
      end
      if (s <= 8'd3 && lo < 8'h80) return m_ram[s[1:0]][lo[6:0]];
      return 8'h00;
   endfunction

   function automatic void m_write(logic [7:0] lo, logic [7:0] v);
      logic [7:0] s;
      s = m_reg[15];
      if (lo >= 8'hF0) m_reg[lo[3:0]] = v;
      else if (s == 8'd0 && lo < 8'h70) m_ram[0][lo[6:0]] = v;
      else if (s >= 8'd1 && s <= 8'd3 && lo < 8'h80) m_ram[s[1:0]][lo[6:0]] = v;
   endfunction

   task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   // compare with the model after every rising edge
   always @(posedge clk) begin
      if (mon_on) begin
         #5;
         checks++;
         if (done !== exp_done) begin
            errors++;
            $display("FAIL %s done actual=%0b expected=%0b", exp_tag, done, exp_done);
         end
         if (exp_done) begin
            check8(exp_tag, "rd_data", rd_data, exp_rd);
            check8(exp_tag, "acc_out", acc_out, exp_acc);
         end
      end
   end

   task automatic do_op(logic [1:0] o, logic [2:0] md, logic [7:0] ib,
                        logic [7:0] a, string tag);
      logic [7:0] lo, val;
      int idx;
      @(negedge clk);
      start = 1'b1; op = o; mode = md; instr_byte = ib; acc_in = a;
      if (md == 3'd0)                          lo = ib;
      else if (md == 3'd1 || md == 3'd3 || md == 3'd4) lo = m_reg[14];
      else                                     lo = m_reg[12];
      val = (md == 3'd7) ? ib : m_read(lo);
      if (md != 3'd7 && (o == 2'd1 || o == 2'd2)) m_write(lo, a);
      if (o != 2'd3 && md >= 3'd3 && md <= 3'd6) begin
         idx = (md <= 3'd4) ? 14 : 12;
         m_reg[idx] = (md == 3'd3 || md == 3'd5) ? m_reg[idx] + 8'd1 : m_reg[idx] - 8'd1;
      end
      exp_done = 1'b1;
      exp_rd   = val;
      exp_acc  = (o == 2'd0 || o == 2'd2) ? val : a;
      exp_tag  = tag;
      cur_acc  = exp_acc;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         exp_done = 1'b0;
      end
   endtask

   task automatic wr(logic [7:0] addr, logic [7:0] v, string tag);
      do_op(2'd1, 3'd0, addr, v, tag);
   endtask

   task automatic rd(logic [7:0] addr, string tag);
      do_op(2'd0, 3'd0, addr, 8'h5A, tag);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      for (int s = 0; s < 4; s++)
         for (int j = 0; j < 128; j++) m_ram[s][j] = '0;

      repeat (3) @(negedge clk);
      // R11 reset values
      check8("R11", "reset done", {7'd0, done}, 8'h00);
      check8("R11", "reset rd_data", rd_data, 8'h00);
      check8("R11", "reset acc_out", acc_out, 8'h00);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(2);

      rd(8'hFE, "R11");                 // registers clear after reset
      rd(8'h33, "R11");
      // R1 direct store and load in segment 0
      wr(8'h10, 8'hC3, "R1");
      rd(8'h10, "R1");
      idle(1);
      // R6 store returns old value, acc unchanged
      wr(8'h10, 8'h44, "R6");
      rd(8'h10, "R6");
      // R7 window layout
      wr(8'hFE, 8'h05, "R7");           // B
      wr(8'hFC, 8'h30, "R7");           // X
      wr(8'hFD, 8'h55, "R7");           // SP
      wr(8'hF3, 8'h9A, "R7");
      wr(8'hFF, 8'h01, "R7");           // S = 1
      rd(8'hF3, "R7");
      rd(8'hFD, "R7");
      // R9 segment 1 RAM
      wr(8'h05, 8'hA7, "R9");
      wr(8'h30, 8'h6E, "R9");
      rd(8'h05, "R9");
      wr(8'h90, 8'h12, "R9");
      rd(8'h90, "R9");
      // R2 pointer-indirect through B and X
      do_op(2'd0, 3'd1, 8'h00, 8'h00, "R2");
      do_op(2'd0, 3'd2, 8'h00, 8'h00, "R2");
      // R7 window shared across segments
      wr(8'hFF, 8'h02, "R7");
      rd(8'hF3, "R7");
      rd(8'h05, "R9");
      // R9 segment above 3 ignores writes and reads zero
      wr(8'hFF, 8'h05, "R9");
      wr(8'h05, 8'h77, "R9");
      rd(8'h05, "R9");
      wr(8'hFF, 8'h01, "R9");
      rd(8'h05, "R9");
      // R5 exchange: acc 01 with location 87
      wr(8'h40, 8'h87, "R5");
      do_op(2'd2, 3'd0, 8'h40, 8'h01, "R5");
      rd(8'h40, "R5");
      // R3 post-increment walk and decrement wrap
      wr(8'hFE, 8'h04, "R3");
      do_op(2'd0, 3'd3, 8'h00, 8'h00, "R3");
      do_op(2'd0, 3'd3, 8'h00, 8'h00, "R3");
      do_op(2'd1, 3'd3, 8'h00, 8'hEE, "R3");
      rd(8'hFE, "R3");
      wr(8'hFE, 8'h00, "R3");
      do_op(2'd0, 3'd4, 8'h00, 8'h00, "R3");
      rd(8'hFE, "R3");
      do_op(2'd0, 3'd3, 8'h00, 8'h00, "R3");   // B=FF reads S, wraps to 00
      rd(8'hFE, "R3");
      wr(8'hFC, 8'h00, "R3");
      do_op(2'd2, 3'd6, 8'h00, 8'h21, "R3");
      rd(8'hFC, "R3");
      // R10 pointer addressing itself
      wr(8'hFC, 8'hFC, "R10");
      do_op(2'd2, 3'd5, 8'h00, 8'h40, "R10");
      rd(8'hFC, "R10");
      wr(8'hFE, 8'hFE, "R10");
      do_op(2'd1, 3'd4, 8'h00, 8'h90, "R10");
      rd(8'hFE, "R10");
      // R4 immediate mode
      do_op(2'd0, 3'd7, 8'h3C, 8'h00, "R4");
      do_op(2'd1, 3'd7, 8'h10, 8'h66, "R4");
      do_op(2'd2, 3'd7, 8'hB1, 8'h66, "R4");
      rd(8'h10, "R4");
      rd(8'hFF, "R4");
      // R8 segment 0 all-ones window ignores writes
      wr(8'hFF, 8'h00, "R8");
      rd(8'h72, "R8");
      wr(8'h7F, 8'h00, "R8");
      rd(8'h7F, "R8");
      rd(8'h6F, "R8");
      // R12 operation code 3
      do_op(2'd3, 3'd0, 8'h10, 8'h11, "R12");
      do_op(2'd3, 3'd5, 8'h00, 8'h11, "R12");
      rd(8'h10, "R12");
      rd(8'hFC, "R12");
      idle(3);

      // mixed stream, back-to-back and with gaps
      for (int n = 0; n < 600; n++) begin
         logic [1:0] o;
         logic [2:0] md;
         logic [7:0] ib;
         o  = 2'($urandom_range(0, 3));
         md = 3'($urandom_range(0, 7));
         ib = 8'($urandom_range(0, 255));
         if (ib == 8'hFF && $urandom_range(0, 3) != 0) ib = 8'($urandom_range(0, 4));
         if ($urandom_range(0, 2) == 0) ib = 8'hF0 | 8'($urandom_range(0, 15));
         do_op(o, md, ib, (n % 3 == 0) ? 8'($urandom_range(0, 255)) : cur_acc, "R6");
         if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule